// File: doc/BRIEF.md
# Exact-Match Destination Address Filter

This block decides whether a received frame should be kept by looking at its 48-bit destination address. A small fully associative table holds up to sixteen station addresses. Each address may be an individual address or a group address, in any mix, and each entry has its own valid flag. Software loads an entry by index and later invalidates it by index. A table hit is an exact 48-bit match, so a frame the table accepts needs no second address check in software.

When the receive path presents a completed destination address with a one-cycle strobe, every valid entry is compared with it at once. One clock later the block reports the verdict:
- whether the table matched, and the index of the matching entry;
- whether the address was the all-ones broadcast;
- whether the frame is accepted.

Broadcast acceptance and a promiscuous accept-everything mode are separate controls outside the table. A full flag tells software that all sixteen entries are in use, so it can fall back to promiscuous mode.

Top module: `addr_cam_filter`

## Requirements
- R1: After reset no entry is valid, `res_valid` and `tbl_full` are 0, and a lookup of any non-broadcast address with both controls off reports `res_hit`=0 and `res_accept`=0.
- R2: A write (`cfg_wr_en`=1, `cfg_clr_en`=0) stores `cfg_addr` at entry `cfg_idx` and marks it valid. A later lookup of that address reports `res_hit`=1 and `res_idx`=`cfg_idx`.
- R3: A match needs all 48 bits equal. An address that differs from every valid entry in at least one bit reports `res_hit`=0.
- R4: A clear (`cfg_clr_en`=1) marks entry `cfg_idx` invalid. A later lookup of its old address does not hit that entry.
- R5: When several valid entries hold the looked-up address, `res_idx` is the lowest of their indices.
- R6: `res_valid` is 1 in exactly the cycle after a cycle with `lk_valid`=1, and 0 otherwise. The other result outputs are updated in that same cycle.
- R7: A table write or clear in the same cycle as a lookup strobe does not affect that lookup. It does affect every later lookup.
- R8: An all-ones address sets `res_bcast`=1 and is accepted when `bcast_en`=1. With `bcast_en`=0 and `promisc_en`=0, it is accepted only if a valid entry holds all ones.
- R9: With `promisc_en`=1 at the strobe, `res_accept`=1 for any address. `res_hit` and `res_idx` still report the table result.
- R10: With both controls off, `res_accept` equals `res_hit`.
- R11: `tbl_full` is 1 exactly when all sixteen entries are valid. It updates in the cycle after the write or clear that changes the count.
- R12: When write and clear are both asserted in one cycle, the clear takes effect and the entry ends invalid.
- R13: Entries holding group addresses (bit 40 of the 48-bit value set; this is the least significant bit of the first transmitted octet) are matched in the same way as individual addresses (bit 40 clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write `cfg_addr` into entry `cfg_idx` and mark it valid |
| cfg_clr_en | input | 1 | Invalidate entry `cfg_idx` (has priority over a write) |
| cfg_idx | input | 4 | Entry index for a write or a clear |
| cfg_addr | input | 48 | Address to store |
| bcast_en | input | 1 | Accept the all-ones broadcast address |
| promisc_en | input | 1 | Accept every frame |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 48 | Destination address to look up |
| res_valid | output | 1 | Verdict valid (cycle after the strobe) |
| res_hit | output | 1 | A valid table entry matched |
| res_idx | output | 4 | Lowest matching entry index |
| res_accept | output | 1 | Frame accepted |
| res_bcast | output | 1 | Looked-up address was all ones |
| tbl_full | output | 1 | All entries valid |

## Verification
Lookups are made with three kinds of address. Stored addresses show that matching and index reporting are correct. Random addresses show that the block rejects non-members. Single-bit neighbours of stored addresses show that the match is exact rather than partial. Duplicate entries at scattered indices show the lowest-index priority. Writes and clears issued in the same cycle as a strobe separate the table state before the edge from the state after it. The broadcast address is swept across all four combinations of the two controls, with and without an all-ones entry, to show that broadcast, promiscuous and table acceptance are three independent paths. Filling and then draining the table checks the full flag at both edges of its count.

// File: rtl/addr_cam_pkg.sv
package addr_cam_pkg;

    localparam int unsigned DEF_ENTRIES = 16;
    localparam int unsigned DEF_ADDR_W  = 48;

    typedef enum logic [1:0] {
        TBL_IDLE  = 2'd0,
        TBL_WRITE = 2'd1,
        TBL_CLEAR = 2'd2
    } tbl_op_e;

    // Clear outranks write when both are requested.
    function automatic tbl_op_e decode_op(input logic wr, input logic clr);
        if (clr)      return TBL_CLEAR;
        else if (wr)  return TBL_WRITE;
        else          return TBL_IDLE;
    endfunction

endpackage

// File: rtl/cam_table.sv
module cam_table
    import addr_cam_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    localparam int unsigned IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  tbl_op_e                          op,
    input  logic [IW-1:0]                    idx,
    input  logic [ADDR_W-1:0]                wdata,
    output logic [ENTRIES-1:0][ADDR_W-1:0]   entry_addr,
    output logic [ENTRIES-1:0]               entry_valid,
    output logic                             full
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic sel;
        assign sel = (idx == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                entry_valid[g] <= 1'b0;
                entry_addr[g]  <= '0;
            end else if (sel) begin
                case (op)
                    TBL_WRITE: begin
                        entry_addr[g]  <= wdata;
                        entry_valid[g] <= 1'b1;
                    end
                    TBL_CLEAR: entry_valid[g] <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    assign full = &entry_valid;

    // R2: a write leaves the addressed entry valid with the written data
    assert_write_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (op == TBL_WRITE) |=> (entry_valid[$past(idx)] && entry_addr[$past(idx)] == $past(wdata)));

    // R4 / R12: a clear (even with a write pending) leaves the entry invalid
    assert_clear_wins_R12: assert property (@(posedge clk) disable iff (rst)
        (op == TBL_CLEAR) |=> !entry_valid[$past(idx)]);

    // R11: a clear always drops the full flag
    assert_full_drops_R11: assert property (@(posedge clk) disable iff (rst)
        (op == TBL_CLEAR) |=> !full);

endmodule

// File: rtl/cam_match.sv
module cam_match #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned ADDR_W  = 48,
    localparam int unsigned IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]   entry_addr,
    input  logic [ENTRIES-1:0]               entry_valid,
    input  logic [ADDR_W-1:0]                key,
    output logic                             hit,
    output logic [IW-1:0]                    hit_idx
);

    logic [ENTRIES-1:0] match_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = entry_valid[g] && (entry_addr[g] == key);
    end

    // Scan downward so the lowest matching index is the last assignment.
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = IW'(i);
        end
    end

    assign hit = |match_vec;

    logic [ENTRIES-1:0] below_mask;
    assign below_mask = (ENTRIES'(1) << hit_idx) - ENTRIES'(1);

    // R2/R3: the reported index really is a matching valid entry
    assert_idx_matches_R3: assert property (@(posedge clk) disable iff (rst)
        hit |-> match_vec[hit_idx]);

    // R5: no matching entry sits below the reported index
    assert_lowest_R5: assert property (@(posedge clk) disable iff (rst)
        hit |-> ((match_vec & below_mask) == '0));

endmodule

// File: rtl/filter_verdict.sv
module filter_verdict #(
    parameter int unsigned ADDR_W = 48,
    parameter int unsigned IW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] key,
    input  logic              hit,
    input  logic [IW-1:0]     hit_idx,
    input  logic              bcast_en,
    input  logic              promisc_en,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IW-1:0]     res_idx,
    output logic              res_accept,
    output logic              res_bcast
);

    logic is_bcast;
    assign is_bcast = &key;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_idx    <= '0;
            res_accept <= 1'b0;
            res_bcast  <= 1'b0;
        end else begin
            res_valid <= strobe;
            if (strobe) begin
                res_hit    <= hit;
                res_idx    <= hit_idx;
                res_bcast  <= is_bcast;
                res_accept <= promisc_en | (bcast_en & is_bcast) | hit;
            end
        end
    end

    // R6: verdict appears in exactly the cycle after a strobe
    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
        strobe |=> res_valid);
    assert_valid_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> !res_valid);

    // R9: promiscuous strobe is always accepted
    assert_promisc_R9: assert property (@(posedge clk) disable iff (rst)
        (strobe && promisc_en) |=> res_accept);

    // R10: with no override, acceptance tracks the table
    assert_plain_R10: assert property (@(posedge clk) disable iff (rst)
        (strobe && !promisc_en && !bcast_en) |=> (res_accept == res_hit));

endmodule

// File: rtl/addr_cam_filter.sv
module addr_cam_filter
    import addr_cam_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    localparam int unsigned IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic              cfg_clr_en,
    input  logic [IW-1:0]     cfg_idx,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              bcast_en,
    input  logic              promisc_en,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IW-1:0]     res_idx,
    output logic              res_accept,
    output logic              res_bcast,
    output logic              tbl_full
);

    tbl_op_e                           op;
    logic [ENTRIES-1:0][ADDR_W-1:0]    entry_addr;
    logic [ENTRIES-1:0]                entry_valid;
    logic                              hit;
    logic [IW-1:0]                     hit_idx;

    assign op = decode_op(cfg_wr_en, cfg_clr_en);

    cam_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_table (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .idx         (cfg_idx),
        .wdata       (cfg_addr),
        .entry_addr  (entry_addr),
        .entry_valid (entry_valid),
        .full        (tbl_full)
    );

    // Compares against registered table state, so same-cycle writes land later.
    cam_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .clk         (clk),
        .rst         (rst),
        .entry_addr  (entry_addr),
        .entry_valid (entry_valid),
        .key         (lk_addr),
        .hit         (hit),
        .hit_idx     (hit_idx)
    );

    filter_verdict #(.ADDR_W(ADDR_W), .IW(IW)) u_verdict (
        .clk        (clk),
        .rst        (rst),
        .strobe     (lk_valid),
        .key        (lk_addr),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .bcast_en   (bcast_en),
        .promisc_en (promisc_en),
        .res_valid  (res_valid),
        .res_hit    (res_hit),
        .res_idx    (res_idx),
        .res_accept (res_accept),
        .res_bcast  (res_bcast)
    );

    // R7: lookup result reflects table state from before a same-cycle write
    assert_write_late_R7: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && cfg_wr_en && !cfg_clr_en && lk_addr == cfg_addr && !hit)
        |=> !res_hit);

endmodule

// File: tb/addr_cam_filter_test.sv
module addr_cam_filter_test;

    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_en, cfg_clr_en;
    logic [3:0]  cfg_idx;
    logic [47:0] cfg_addr;
    logic        bcast_en, promisc_en;
    logic        lk_valid;
    logic [47:0] lk_addr;
    logic        res_valid, res_hit, res_accept, res_bcast, tbl_full;
    logic [3:0]  res_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [47:0] m_addr [N];
    logic        m_val  [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_cam_filter uut (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_clr_en(cfg_clr_en), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr),
        .bcast_en(bcast_en), .promisc_en(promisc_en),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
        .res_accept(res_accept), .res_bcast(res_bcast), .tbl_full(tbl_full)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit model_full();
        for (int i = 0; i < N; i++) if (!m_val[i]) return 0;
        return 1;
    endfunction

    // One cycle: drive at negedge, model before the edge, check at the next negedge.
    task automatic step(input bit wr, input bit clr, input int idx, input logic [47:0] a,
                        input bit lk, input logic [47:0] k, input bit bc, input bit pr,
                        input string req);
        bit eh; int ei; bit ea;
        eh = 0; ei = 0;
        for (int i = N - 1; i >= 0; i--)
            if (m_val[i] && m_addr[i] == k) begin eh = 1; ei = i; end
        ea = pr | (bc & (&k)) | eh;
        cfg_wr_en = wr; cfg_clr_en = clr; cfg_idx = idx[3:0]; cfg_addr = a;
        lk_valid = lk; lk_addr = k; bcast_en = bc; promisc_en = pr;
        @(negedge clk);
        if (clr) m_val[idx] = 0;
        else if (wr) begin m_val[idx] = 1; m_addr[idx] = a; end
        cfg_wr_en = 0; cfg_clr_en = 0; lk_valid = 0;
        check(res_valid == lk, {"R6 ", req}, res_valid, lk);
        check(tbl_full == model_full(), {"R11 ", req}, tbl_full, model_full());
        if (lk) begin
            check(res_hit == eh, {req, " hit"}, res_hit, eh);
            if (eh) check(res_idx == ei[3:0], {req, " idx"}, res_idx, ei);
            check(res_accept == ea, {req, " accept"}, res_accept, ea);
            check(res_bcast == (&k), {"R8 ", req, " bcast"}, res_bcast, &k);
        end
    endtask

    task automatic wr_e(input int idx, input logic [47:0] a, input string req);
        step(1, 0, idx, a, 0, '0, 0, 0, req);
    endtask
    task automatic clr_e(input int idx, input string req);
        step(0, 1, idx, '0, 0, '0, 0, 0, req);
    endtask
    task automatic look(input logic [47:0] k, input bit bc, input bit pr, input string req);
        step(0, 0, 0, '0, 1, k, bc, pr, req);
    endtask

    function automatic logic [47:0] rnd48();
        return {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [47:0] a0, a1, g0, bc;
        void'($urandom(32'd20231));
        for (int i = 0; i < N; i++) begin m_val[i] = 0; m_addr[i] = '0; end
        bc = '1;
        rst = 1; cfg_wr_en = 0; cfg_clr_en = 0; cfg_idx = 0; cfg_addr = 0;
        lk_valid = 0; lk_addr = 0; bcast_en = 0; promisc_en = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check(res_valid == 0 && tbl_full == 0, "R1 reset outputs", {res_valid, tbl_full}, 0);
        a0 = 48'h0011_2233_4454;
        look(a0, 0, 0, "R1 empty lookup");
        // R2 / R13 individual and group entries
        g0 = 48'h0100_5E00_00FB;
        wr_e(5, a0, "R2 write");
        wr_e(9, g0, "R13 write group");
        look(a0, 0, 0, "R2 individual");
        look(g0, 0, 0, "R13 group");
        // R3 single-bit neighbours
        for (int b = 0; b < 48; b += 7) look(a0 ^ (48'd1 << b), 0, 0, "R3 neighbour");
        look(a0 ^ (48'd1 << 47), 0, 0, "R3 top bit");
        // R5 duplicates
        wr_e(12, a0, "R5 dup high");
        wr_e(2, a0, "R5 dup low");
        look(a0, 0, 0, "R5 lowest");
        // R4 clear
        clr_e(2, "R4 clear");
        look(a0, 0, 0, "R4 after clear");
        // R7 same-cycle write
        a1 = 48'hA0B0_C0D0_E0F0;
        step(1, 0, 0, a1, 1, a1, 0, 0, "R7 same cycle");
        look(a1, 0, 0, "R7 next lookup");
        step(0, 1, 0, '0, 1, a1, 0, 0, "R7 same cycle clear");
        look(a1, 0, 0, "R7 after clear");
        // R8 / R9 / R10 broadcast sweep
        for (int c = 0; c < 4; c++) look(bc, c[0], c[1], "R8 bcast sweep");
        wr_e(14, bc, "R8 bcast entry");
        for (int c = 0; c < 4; c++) look(bc, c[0], c[1], "R8 bcast in table");
        clr_e(14, "R8 remove");
        look(rnd48() & ~48'h1, 0, 1, "R9 promisc");
        look(a0, 1, 0, "R10 hit no override");
        // R12 write and clear together
        step(1, 1, 7, a1, 0, '0, 0, 0, "R12 both");
        look(a1, 0, 0, "R12 cleared");
        // R11 fill and drain
        for (int i = 0; i < N; i++) wr_e(i, 48'h0200_0000_0000 + 48'(i), "R11 fill");
        check(tbl_full == 1, "R11 full", tbl_full, 1);
        clr_e(3, "R11 drop");
        check(tbl_full == 0, "R11 not full", tbl_full, 0);
        // random mix
        for (int t = 0; t < 600; t++) begin
            int op; int ix; logic [47:0] k;
            op = $urandom_range(0, 9); ix = $urandom_range(0, N - 1);
            k = ($urandom_range(0, 1) == 1) ? m_addr[$urandom_range(0, N - 1)] : rnd48();
            if ($urandom_range(0, 15) == 0) k = bc;
            if (op < 2) step(1, 0, ix, rnd48(), op[0], k, $urandom_range(0,1) == 1, 0, "R2 rand write");
            else if (op < 3) step(0, 1, ix, '0, 1, k, 0, 0, "R4 rand clear");
            else step(0, 0, 0, '0, 1, k, $urandom_range(0,1) == 1, $urandom_range(0,7) == 0, "R10 rand lookup");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule